// File: doc/BRIEF.md
# Brute-Force Core Fill Scheduler

This block is the global scheduler of a password search engine. It accepts one work block, made of a starting candidate and a candidate count, and hands candidates from a shared counter-style generator to a row of hashing cores. Each core takes one candidate per pipeline slot, and a full batch fills every slot. The scheduler fills the cores one after another while the generator runs. When the last core is full, the generator is frozen until every loaded core has drained. Then a new round starts from the first core.

A round ends early when the generator runs out. The core that was being filled is padded with slots flagged invalid, and the cores after it are left out of that round. After each round the scheduler reads the found flag and the slot index of every core that took part. It stops on the first valid match, or when the block is used up. It reports a hit flag and the numeric offset of the matching candidate from the start value. It never reports the candidate itself.

Top module: `bf_fill_sched`

## Requirements
- R1: After reset the block is idle. `blk_ready` is 1, and `core_load`, `cand_valid` and `res_valid` are 0.
- R2: In a round, the loaded cores are strobed one at a time in ascending index order, starting at core 0. Each loaded core receives exactly SLOTS consecutive load strobes, with slot indices 0 to SLOTS-1 on `cand_slot`.
- R3: The valid candidates of a block are start+0, start+1, … in strobe order, with no gaps or repeats. `cand_valid` is 1 only together with a load strobe, and the generator count does not move while no candidate is taken.
- R4: Once the last core of a round is filled, no strobe is issued until every core loaded in that round has `core_busy` low. The next round then starts again at core 0.
- R5: When the count is used up inside a core's batch, that core still receives SLOTS strobes, with `cand_valid`=0 on the unused slots. When the count runs out, whether inside a batch or at a core boundary, the higher cores get no strobes in that round.
- R6: A match is taken from a loaded core whose found flag is set and whose slot holds a valid candidate. The offset is the index of that core's first candidate in the round plus its reported slot. If several cores match, the lowest core index wins. The result comes out as a one-cycle `res_valid` with `res_hit`=1.
- R7: A found flag from a core not loaded in the current round, or one pointing at an invalid (padding) slot, is ignored.
- R8: When the block is used up without a valid match, the block reports `res_valid` with `res_hit`=0 and returns to idle (`blk_ready`=1) in the same cycle.
- R9: A block with a count of zero is answered in the next cycle with `res_valid`=1 and `res_hit`=0, and no core is loaded.
- R10: `blk_valid` is ignored while `blk_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_valid | input | 1 | Offer of a new work block |
| blk_start | input | CAND_W | First candidate value of the block |
| blk_len | input | CNT_W | Number of candidates in the block |
| blk_ready | output | 1 | Idle and able to accept a block |
| cand_data | output | CAND_W | Candidate presented with a load strobe |
| cand_valid | output | 1 | Presented slot holds a real candidate |
| cand_slot | output | 8 | Slot index within the core batch |
| core_load | output | NUM_CORES | Per-core load strobe |
| core_busy | input | NUM_CORES | Core still working on its batch |
| core_found | input | NUM_CORES | Core saw a matching candidate |
| core_slot | input | 8*NUM_CORES | Slot of the match, 8 bits per core |
| res_valid | output | 1 | One-cycle result pulse |
| res_hit | output | 1 | Result is a match |
| res_offset | output | CNT_W | Offset of the match from the start value |

## Verification
The blocks are sized to place the end of the count at a single candidate, at an exact core boundary, at an exact round boundary, mid-batch in the last core, and one past a target. These sizes separate padding errors from errors that skip or add cores. Multi-round blocks with a late target check the drain wait and the restart at core 0. Forced found flags on unloaded cores, on padding slots, and on a higher core alongside a real match tell the valid-slot gating apart from the core priority. Random starts, counts and target offsets with varying core latencies cover the offset arithmetic across rounds.

// File: rtl/bf_fill_pkg.sv
package bf_fill_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_WAIT = 2'd2
    } sched_st_e;
endpackage

// File: rtl/bf_cand_gen.sv
module bf_cand_gen #(
    parameter int CNT_W  = 32,
    parameter int CAND_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [CAND_W-1:0] start_val,
    input  logic              en,
    output logic [CNT_W-1:0]  count,
    output logic [CAND_W-1:0] cand
);
    typedef struct packed {
        logic [CAND_W-1:0] start;
        logic [CNT_W-1:0]  count;
    } gen_t;

    gen_t gen_d, gen_q;

    always_comb begin
        gen_d = gen_q;
        if (clr) begin
            gen_d.start = start_val;
            gen_d.count = '0;
        end else if (en) begin
            gen_d.count = gen_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign count = gen_q.count;
    assign cand  = gen_q.start + CAND_W'(gen_q.count);

    AST_GEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(count)); // R3
endmodule

// File: rtl/bf_hit_sel.sv
module bf_hit_sel #(
    parameter int NUM_CORES = 4,
    parameter int SLOTS     = 83,
    parameter int CNT_W     = 32
) (
    input  logic [NUM_CORES-1:0]       active,
    input  logic [NUM_CORES-1:0]       found,
    input  logic [8*NUM_CORES-1:0]     slot_flat,
    input  logic [CNT_W*NUM_CORES-1:0] base_flat,
    input  logic [CNT_W-1:0]           len,
    output logic                       hit,
    output logic [CNT_W-1:0]           offset
);
    logic [CNT_W:0]       ofs_w [NUM_CORES];
    logic [NUM_CORES-1:0] ok;

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        logic [7:0]       slot_g;
        logic [CNT_W-1:0] base_g;
        assign slot_g   = slot_flat[8*g +: 8];
        assign base_g   = base_flat[CNT_W*g +: CNT_W];
        assign ofs_w[g] = {1'b0, base_g} + (CNT_W+1)'(slot_g);
        assign ok[g]    = active[g] && found[g] && (int'(slot_g) < SLOTS)
                          && (ofs_w[g] < {1'b0, len});
    end

    always_comb begin
        hit    = 1'b0;
        offset = '0;
        for (int i = NUM_CORES - 1; i >= 0; i--) begin
            if (ok[i]) begin
                hit    = 1'b1;
                offset = ofs_w[i][CNT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/bf_fill_sched.sv
module bf_fill_sched
    import bf_fill_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int SLOTS     = 83,
    parameter int CNT_W     = 32,
    parameter int CAND_W    = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   blk_valid,
    input  logic [CAND_W-1:0]      blk_start,
    input  logic [CNT_W-1:0]       blk_len,
    output logic                   blk_ready,
    output logic [CAND_W-1:0]      cand_data,
    output logic                   cand_valid,
    output logic [7:0]             cand_slot,
    output logic [NUM_CORES-1:0]   core_load,
    input  logic [NUM_CORES-1:0]   core_busy,
    input  logic [NUM_CORES-1:0]   core_found,
    input  logic [8*NUM_CORES-1:0] core_slot,
    output logic                   res_valid,
    output logic                   res_hit,
    output logic [CNT_W-1:0]       res_offset
);
    localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
    localparam logic [CORE_W-1:0] LAST_CORE = CORE_W'(NUM_CORES - 1);
    localparam logic [7:0]        LAST_SLOT = 8'(SLOTS - 1);

    typedef struct packed {
        sched_st_e            st;
        logic [CORE_W-1:0]    core;
        logic [7:0]           slot;
        logic [CNT_W-1:0]     len;
        logic [NUM_CORES-1:0] active;
        logic                 rv;
        logic                 rh;
        logic [CNT_W-1:0]     ro;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic [CNT_W-1:0] base_d [NUM_CORES];
    logic [CNT_W-1:0] base_q [NUM_CORES];

    logic                       gen_clr, gen_en;
    logic [CNT_W-1:0]           gen_count;
    logic                       exhausted, will_exh, all_idle, sel_hit;
    logic [CNT_W:0]             nxt_cnt;
    logic [CNT_W-1:0]           sel_off;
    logic [CNT_W*NUM_CORES-1:0] base_flat;

    bf_cand_gen #(.CNT_W(CNT_W), .CAND_W(CAND_W)) gen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (gen_clr),
        .start_val (blk_start),
        .en        (gen_en),
        .count     (gen_count),
        .cand      (cand_data)
    );

    always_comb begin
        for (int i = 0; i < NUM_CORES; i++) base_flat[CNT_W*i +: CNT_W] = base_q[i];
    end

    bf_hit_sel #(.NUM_CORES(NUM_CORES), .SLOTS(SLOTS), .CNT_W(CNT_W)) sel_i (
        .active    (ctl_q.active),
        .found     (core_found),
        .slot_flat (core_slot),
        .base_flat (base_flat),
        .len       (ctl_q.len),
        .hit       (sel_hit),
        .offset    (sel_off)
    );

    assign exhausted = (gen_count >= ctl_q.len);
    assign all_idle  = ((core_busy & ctl_q.active) == '0);
    assign nxt_cnt   = {1'b0, gen_count} + (CNT_W+1)'(gen_en);
    assign will_exh  = (nxt_cnt >= {1'b0, ctl_q.len});

    always_comb begin
        ctl_d      = ctl_q;
        base_d     = base_q;
        ctl_d.rv   = 1'b0;
        gen_clr    = 1'b0;
        gen_en     = 1'b0;
        core_load  = '0;
        cand_valid = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (blk_valid) begin
                    if (blk_len == '0) begin
                        ctl_d.rv = 1'b1;
                        ctl_d.rh = 1'b0;
                        ctl_d.ro = '0;
                    end else begin
                        gen_clr      = 1'b1;
                        ctl_d.len    = blk_len;
                        ctl_d.st     = ST_FILL;
                        ctl_d.core   = '0;
                        ctl_d.slot   = '0;
                        ctl_d.active = '0;
                    end
                end
            end
            ST_FILL: begin
                core_load[ctl_q.core] = 1'b1;
                gen_en     = !exhausted;
                cand_valid = !exhausted;
                if (ctl_q.slot == '0) begin
                    base_d[ctl_q.core]       = gen_count;
                    ctl_d.active[ctl_q.core] = 1'b1;
                end
                if (ctl_q.slot == LAST_SLOT) begin
                    ctl_d.slot = '0;
                    if (ctl_q.core == LAST_CORE || will_exh) ctl_d.st = ST_WAIT;
                    else ctl_d.core = ctl_q.core + 1'b1;
                end else begin
                    ctl_d.slot = ctl_q.slot + 1'b1;
                end
            end
            ST_WAIT: begin
                if (all_idle) begin
                    if (sel_hit || exhausted) begin
                        ctl_d.rv = 1'b1;
                        ctl_d.rh = sel_hit;
                        ctl_d.ro = sel_hit ? sel_off : '0;
                        ctl_d.st = ST_IDLE;
                    end else begin
                        ctl_d.st     = ST_FILL;
                        ctl_d.core   = '0;
                        ctl_d.active = '0;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            for (int i = 0; i < NUM_CORES; i++) base_q[i] <= '0;
        end else begin
            ctl_q  <= ctl_d;
            base_q <= base_d;
        end
    end

    assign blk_ready  = (ctl_q.st == ST_IDLE);
    assign cand_slot  = ctl_q.slot;
    assign res_valid  = ctl_q.rv;
    assign res_hit    = ctl_q.rh;
    assign res_offset = ctl_q.ro;

    AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(core_load)); // R2
    AST_CAND_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> (core_load != '0)); // R3
    AST_WAIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_WAIT) |=> $stable(gen_count)); // R4
    AST_HIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |-> (res_offset < ctl_q.len)); // R6
    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_ready && blk_valid && blk_len == '0) |=> (res_valid && !res_hit)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        blk_ready |-> (core_load == '0)); // R10
endmodule

// File: tb/bf_fill_sched_tb_top.sv
module bf_fill_sched_tb_top;
    localparam int N      = 4;
    localparam int S      = 83;
    localparam int CNT_W  = 32;
    localparam int CAND_W = 64;
    localparam int ROUND  = N * S;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              blk_valid = 1'b0;
    logic [CAND_W-1:0] blk_start = '0;
    logic [CNT_W-1:0]  blk_len = '0;
    logic              blk_ready;
    logic [CAND_W-1:0] cand_data;
    logic              cand_valid;
    logic [7:0]        cand_slot;
    logic [N-1:0]      core_load;
    logic [N-1:0]      core_busy;
    logic [N-1:0]      core_found;
    logic [8*N-1:0]    core_slot;
    logic              res_valid;
    logic              res_hit;
    logic [CNT_W-1:0]  res_offset;

    always #2 clk = ~clk;

    bf_fill_sched #(.NUM_CORES(N), .SLOTS(S), .CNT_W(CNT_W), .CAND_W(CAND_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_start(blk_start),
        .blk_len(blk_len), .blk_ready(blk_ready), .cand_data(cand_data),
        .cand_valid(cand_valid), .cand_slot(cand_slot), .core_load(core_load),
        .core_busy(core_busy), .core_found(core_found), .core_slot(core_slot),
        .res_valid(res_valid), .res_hit(res_hit), .res_offset(res_offset)
    );

    int errs = 0;
    int checks = 0;
    int cycles = 0;

    // core models
    logic [N-1:0]      m_busy, m_found, m_seen;
    logic [7:0]        m_slot [N];
    logic [7:0]        m_tslot [N];
    int                m_lcnt [N];
    int                m_lat [N];
    logic [N-1:0]      inj_en = '0;
    logic [7:0]        inj_slot [N];
    logic              tgt_en = 1'b0;
    logic [CAND_W-1:0] tgt_val = '0;

    assign core_busy = m_busy;
    for (genvar g = 0; g < N; g++) begin : g_out
        assign core_found[g]       = m_found[g] | inj_en[g];
        assign core_slot[8*g +: 8] = inj_en[g] ? inj_slot[g] : m_slot[g];
    end

    always @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) begin
                m_busy[i] <= 1'b0; m_found[i] <= 1'b0; m_seen[i] <= 1'b0;
                m_slot[i] <= '0; m_tslot[i] <= '0; m_lcnt[i] <= 0; m_lat[i] <= 0;
            end else if (core_load[i]) begin
                m_busy[i] <= 1'b1;
                if (m_lcnt[i] == 0) begin m_found[i] <= 1'b0; m_seen[i] <= 1'b0; end
                if (cand_valid && tgt_en && cand_data == tgt_val) begin
                    m_seen[i] <= 1'b1; m_tslot[i] <= 8'(m_lcnt[i]);
                end
                if (m_lcnt[i] == S - 1) begin
                    m_lcnt[i] <= 0; m_lat[i] <= 1 + int'($urandom % 16);
                end else m_lcnt[i] <= m_lcnt[i] + 1;
            end else if (m_busy[i] && m_lat[i] != 0) begin
                if (m_lat[i] == 1) begin
                    m_busy[i] <= 1'b0; m_found[i] <= m_seen[i]; m_slot[i] <= m_tslot[i];
                end
                m_lat[i] <= m_lat[i] - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor
    logic [CAND_W-1:0] mon_start;
    longint mon_vcnt, mon_loads;
    int     run_idx, run_len;
    bit     pad_seen, prev_load;

    always @(negedge clk) begin
        if (rst_n) begin
            if (core_load != '0) begin
                int idx = 0;
                for (int i = 0; i < N; i++) if (core_load[i]) idx = i;
                mon_loads++;
                if (cand_valid) begin
                    if (cand_data != mon_start + CAND_W'(mon_vcnt) || pad_seen)
                        chk(0, "R3 candidate order", longint'(cand_data), longint'(mon_start) + mon_vcnt);
                    mon_vcnt++;
                end else pad_seen = 1;
                if (run_len > 0 && idx == run_idx) begin
                    run_len++;
                end else begin
                    if (run_len > 0) chk(run_len == S, "R2 batch length", run_len, S);
                    if (idx == 0 && run_len > 0)
                        chk(!prev_load && m_busy == '0, "R4 drain before refill", longint'(m_busy), 0);
                    else if (idx != 0)
                        chk(prev_load && idx == run_idx + 1, "R2 core order", idx, run_idx + 1);
                    run_idx = idx; run_len = 1;
                end
                if (int'(cand_slot) != run_len - 1)
                    chk(0, "R2 slot index", cand_slot, run_len - 1);
                prev_load = 1;
            end else begin
                if (cand_valid) chk(0, "R3 valid without load", 1, 0);
                prev_load = 0;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            chk(0, "watchdog", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    function automatic longint exp_vtot(longint len, bit hit, longint off);
        longint lim;
        if (!hit) return len;
        lim = (off / ROUND + 1) * ROUND;
        return (lim < len) ? lim : len;
    endfunction

    task automatic run_block(input logic [CAND_W-1:0] st, input longint len,
                             input bit has_tgt, input longint toff,
                             input bit exp_hit, input longint exp_off,
                             input bit poke, input string req);
        longint vt, ld;
        int     w;
        @(negedge clk);
        mon_start = st; mon_vcnt = 0; mon_loads = 0;
        run_len = 0; run_idx = 0; pad_seen = 0;
        tgt_en = has_tgt; tgt_val = st + CAND_W'(toff);
        blk_start = st; blk_len = CNT_W'(len); blk_valid = 1'b1;
        @(negedge clk);
        blk_valid = 1'b0;
        if (poke) begin
            repeat (40) @(negedge clk);
            chk(blk_ready == 1'b0, "R10 busy not ready", blk_ready, 0);
            blk_start = 64'hDEAD; blk_len = '0; blk_valid = 1'b1;
            @(negedge clk);
            blk_valid = 1'b0;
        end
        w = 0;
        while (!res_valid && w < 20000) begin @(negedge clk); w++; end
        chk(res_valid == 1'b1, {req, " result seen"}, res_valid, 1);
        chk(res_hit == exp_hit, {req, " hit flag"}, res_hit, exp_hit);
        if (exp_hit) chk(res_offset == CNT_W'(exp_off), {req, " offset"}, res_offset, exp_off);
        chk(blk_ready == 1'b1, "R8 back to idle", blk_ready, 1);
        if (run_len > 0) chk(run_len == S, "R2 last batch length", run_len, S);
        vt = exp_vtot(len, exp_hit, exp_off);
        ld = ((vt + S - 1) / S) * S;
        chk(mon_vcnt == vt, "R3 valid candidates issued", mon_vcnt, vt);
        chk(mon_loads == ld, "R5 strobes issued", mon_loads, ld);
        @(negedge clk);
        chk(res_valid == 1'b0, "R6 result is a pulse", res_valid, 0);
        tgt_en = 1'b0; inj_en = '0;
    endtask

    initial begin
        void'($urandom(32'd12345));
        for (int i = 0; i < N; i++) inj_slot[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(blk_ready == 1'b1 && core_load == '0 && !res_valid && !cand_valid,
            "R1 reset state", {blk_ready, core_load, res_valid, cand_valid}, 64);

        // R9 zero-length block
        blk_len = '0; blk_start = 64'd7; blk_valid = 1'b1;
        @(negedge clk);
        blk_valid = 1'b0;
        chk(res_valid && !res_hit, "R9 zero length answered", {res_valid, res_hit}, 2);
        chk(core_load == '0, "R9 no load", core_load, 0);

        run_block(64'd1000, 1, 1, 0, 1, 0, 0, "R6 single candidate");
        run_block(64'd50, ROUND, 0, 0, 0, 0, 0, "R8 round-exact end");
        run_block(64'd9, 2 * S, 0, 0, 0, 0, 0, "R5 core-boundary end");
        run_block(64'h100, 700, 1, 500, 1, 500, 0, "R4 multi-round hit");
        inj_en[3] = 1'b1; inj_slot[3] = 8'd0;
        run_block(64'd77, 100, 0, 0, 0, 0, 0, "R7 unloaded core found");
        inj_en[3] = 1'b1; inj_slot[3] = 8'd82;
        run_block(64'd77, 259, 0, 0, 0, 0, 0, "R7 padding slot found");
        inj_en[3] = 1'b1; inj_slot[3] = 8'd5;
        run_block(64'd77, 259, 0, 0, 1, 254, 0, "R6 partial batch hit");
        inj_en[2] = 1'b1; inj_slot[2] = 8'd5;
        run_block(64'h5000, 1000, 1, 100, 1, 100, 1, "R6 lowest core wins");
        run_block(64'hFFFF_FFFF_FFFF_FF00, 400, 1, 400, 0, 0, 0, "R8 target past end");

        for (int k = 0; k < 8; k++) begin
            logic [CAND_W-1:0] st;
            longint len, toff;
            st   = {$urandom, $urandom};
            len  = 1 + longint'($urandom % 900);
            toff = longint'($urandom % 1000);
            run_block(st, len, 1, toff, toff < len, toff, 0, "R6 random block");
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule